// File: doc/BRIEF.md
# Dual Transaction Watchdog Timers

This block guards a command path with two independent one-shot countdown watchdogs. Each is configured through its own 32-bit register on a small memory-mapped slave port. The command watchdog catches a transaction that starts but never ends. It arms when the host writes a command data word and is stood down when the host writes the command's last word. The backpressure watchdog watches a valid/ready handshake toward the command consumer. It trips when ready stays low too long while a command word is waiting.

When a watchdog expires, it clears its own enable bit and sets its own bit in an interrupt status register. That bit stays set until software writes 1 to it. A single interrupt line is high while any status bit is set. After a timeout, software re-enables a watchdog by writing its register again.

Top module: `txn_watchdog_pair`

## Requirements
- R1: After reset, both timer registers read 0x7FFF_FFFF: enable bit 31 is 0 and the period in bits 30:0 is all ones. The status register reads 0 and `irq` is low.
- R2: Word offset 2 is the command timer register and offset 3 is the backpressure timer register. A write stores enable from bit 31 and the period from bits 30:0, and reading the register returns them unchanged. A read is combinational while `bus_rd` is high.
- R3: With the command timer enabled and idle, a write to offset 0 arms it with period N. If no completing write follows, the timer expires on the (N+1)th clock edge after the arming edge. The expiry sets status bit 4 (offset 4).
- R4: A write to offset 1 while the command timer runs stops it and reloads the period. This write wins over an expiry that falls on the same edge. A later write to offset 0 re-arms the timer with the full period. Further writes to offset 0 while the timer runs do not restart it.
- R5: While a timer's enable bit is 0, no write and no handshake activity can cause a timeout.
- R6: With the backpressure timer enabled and period N, the (N+1)th consecutive cycle with `cmd_valid` high and `cmd_ready` low sets status bit 5. N such cycles do not set it.
- R7: The backpressure count reloads on any cycle where `cmd_ready` is high or `cmd_valid` is low.
- R8: On expiry, a timer clears its enable bit and keeps its period. It causes no further timeout until software sets the enable again.
- R9: Writing 1 to status bit 4 or 5 clears it, and writing 0 leaves it unchanged. A bit stays set after its timer is re-enabled. When a new timeout and a clearing write fall on the same edge, the bit ends up set.
- R10: A period of 0 expires on the first clock edge after the timer is armed. For the backpressure timer, that is the first stalled cycle.
- R11: A write to a timer register while that timer is counting reloads its counter with the newly written period.
- R12: `irq` is high exactly when status bit 4 or bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word offset: 0 cmd data, 1 cmd last, 2 cmd timer, 3 bp timer, 4 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, 0 when not reading or for offsets 0, 1 and unmapped |
| cmd_valid | input | 1 | A command word is pending toward the consumer |
| cmd_ready | input | 1 | Consumer accepts the pending word |
| irq | output | 1 | OR of the status bits |

## Verification
Two pairs of events can meet on one clock edge. A completing last-word write can land exactly on the edge where the command timer would expire, and the write must win. A write-1 clear of status bit 4 can land on the edge of a fresh period-0 expiry, and the bit must stay set. Both cases are staged with exact write timing and judged by reading the status register on the next cycle. Random valid/ready streams with random short periods are scored against a bench model that counts consecutive stalled cycles.

// File: rtl/wdp_pkg.sv
// Shared definitions for the dual watchdog block: register offsets,
// status bit positions and the timer variant selector.
package wdp_pkg;

    // Word offsets on the slave port
    localparam int OFF_CMD_DATA = 0;
    localparam int OFF_CMD_LAST = 1;
    localparam int OFF_CMD_TMR  = 2;
    localparam int OFF_BP_TMR   = 3;
    localparam int OFF_STATUS   = 4;

    // Status bit positions inside the status word
    localparam int ST_CMD_BIT = 4;
    localparam int ST_BP_BIT  = 5;

    // Event mode: start/stop pulses; level mode: stall level with reload
    typedef enum logic {
        WD_EVENT = 1'b0,
        WD_LEVEL = 1'b1
    } wd_mode_e;

endpackage

// File: rtl/wd_countdown.sv
// One-shot watchdog countdown with enable and period register.
// MODE=WD_EVENT: start_i arms an idle timer, stop_i stands it down.
// MODE=WD_LEVEL: counts while start_i (pending) is high and stop_i (accept)
// is low; reloads otherwise. Assumes cfg_we is a single-cycle write strobe.
// On expiry the enable clears and timeout_o pulses for one cycle.
module wd_countdown
    import wdp_pkg::*;
#(
    parameter wd_mode_e MODE  = WD_EVENT,
    parameter int       PER_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_en,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             en_o,
    output logic [PER_W-1:0] period_o,
    output logic             timeout_o
);

    localparam logic [PER_W-1:0] PER_DEFAULT = {PER_W{1'b1}};
    localparam logic [PER_W-1:0] PER_ZERO    = '0;
    localparam logic [PER_W-1:0] PER_ONE     = PER_W'(1);

    logic             en_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] cnt_q;
    logic             expire;

    // Enable and period register: software write, self-clear on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            per_q <= PER_DEFAULT;
        end else if (cfg_we) begin
            en_q  <= cfg_en;
            per_q <= cfg_period;
        end else if (expire) begin
            en_q  <= 1'b0;
        end
    end

    generate
        if (MODE == WD_EVENT) begin : g_event
            logic run_q;

            assign expire = en_q && run_q && !cfg_we && !stop_i && (cnt_q == PER_ZERO);

            // Arm on start, stand down on stop, count down while running
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= 1'b0;
                    cnt_q <= PER_DEFAULT;
                end else if (cfg_we) begin
                    cnt_q <= cfg_period;
                    if (!cfg_en) begin
                        run_q <= 1'b0;
                    end
                end else if (en_q) begin
                    if (!run_q) begin
                        if (start_i) begin
                            run_q <= 1'b1;
                            cnt_q <= per_q;
                        end
                    end else if (stop_i) begin
                        run_q <= 1'b0;
                        cnt_q <= per_q;
                    end else if (cnt_q == PER_ZERO) begin
                        run_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - PER_ONE;
                    end
                end
            end

            // R4: a completing write stops the timer and keeps it enabled
            p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (en_q && run_q && stop_i && !cfg_we) |=> (!run_q && en_q));

            // R5: a disabled timer cannot become armed
            p_idle_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!en_q && !cfg_we) |=> !run_q);
        end else begin : g_level
            assign expire = en_q && start_i && !stop_i && !cfg_we && (cnt_q == PER_ZERO);

            // Count down stalled cycles, reload whenever not stalled
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= PER_DEFAULT;
                end else if (cfg_we) begin
                    cnt_q <= cfg_period;
                end else if (en_q) begin
                    if (!start_i || stop_i) begin
                        cnt_q <= per_q;
                    end else if (cnt_q != PER_ZERO) begin
                        cnt_q <= cnt_q - PER_ONE;
                    end
                end
            end

            // R7: no stall this cycle means a full period next cycle
            p_bp_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (en_q && !cfg_we && (!start_i || stop_i)) |=> (cnt_q == $past(per_q)));
        end
    endgenerate

    assign en_o      = en_q;
    assign period_o  = per_q;
    assign timeout_o = expire;

    // R8: expiry drops the enable
    p_expire_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !en_q);

    // R8: expiry leaves the period untouched
    p_period_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (per_q == $past(per_q)));

    // R11: a register write reloads the counter with the new period
    p_cfg_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cnt_q == $past(cfg_period)));

endmodule

// File: rtl/wd_regbank.sv
// Address decode, timer register readback and sticky write-1-to-clear
// status bits for the two watchdogs. Assumes at most one write per cycle;
// reads are combinational and side-effect free.
module wd_regbank
    import wdp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_to,
    input  logic              bp_to,
    input  logic              cmd_en,
    input  logic [DATA_W-2:0] cmd_per,
    input  logic              bp_en,
    input  logic [DATA_W-2:0] bp_per,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        status_o,
    output logic              cmd_cfg_we,
    output logic              bp_cfg_we,
    output logic              cmd_first,
    output logic              cmd_last
);

    logic       st_we;
    logic [1:0] st_q;
    logic [1:0] to_vec;
    logic [1:0] clr_vec;

    // Write strobes decoded per offset
    always_comb begin
        cmd_first  = wr_en && (addr == ADDR_W'(OFF_CMD_DATA));
        cmd_last   = wr_en && (addr == ADDR_W'(OFF_CMD_LAST));
        cmd_cfg_we = wr_en && (addr == ADDR_W'(OFF_CMD_TMR));
        bp_cfg_we  = wr_en && (addr == ADDR_W'(OFF_BP_TMR));
        st_we      = wr_en && (addr == ADDR_W'(OFF_STATUS));
    end

    assign to_vec  = {bp_to, cmd_to};
    assign clr_vec = st_we ? {wdata[ST_BP_BIT], wdata[ST_CMD_BIT]} : 2'b00;

    // Sticky status bits: a timeout sets, a written 1 clears, set wins
    generate
        for (genvar i = 0; i < 2; i++) begin : g_status
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q[i] <= 1'b0;
                end else if (to_vec[i]) begin
                    st_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    st_q[i] <= 1'b0;
                end
            end

            // R9: a timeout always leaves the bit set
            p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
                to_vec[i] |=> st_q[i]);

            // R9: a set bit persists unless a 1 is written to it
            p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q[i] && !clr_vec[i]) |=> st_q[i]);

            // R9: a clearing write with no new timeout empties the bit
            p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !to_vec[i]) |=> !st_q[i]);
        end
    endgenerate

    // Read multiplexer for timer registers and status
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFF_CMD_TMR)) begin
                rdata = {cmd_en, cmd_per};
            end else if (addr == ADDR_W'(OFF_BP_TMR)) begin
                rdata = {bp_en, bp_per};
            end else if (addr == ADDR_W'(OFF_STATUS)) begin
                rdata[ST_CMD_BIT] = st_q[0];
                rdata[ST_BP_BIT]  = st_q[1];
            end
        end
    end

    assign status_o = st_q;

endmodule

// File: rtl/txn_watchdog_pair.sv
// Top level: slave register port plus two one-shot watchdogs, one for
// unfinished command transactions and one for prolonged backpressure.
// Assumes DATA_W >= 6 so that both status bits fit in the data word.
module txn_watchdog_pair
    import wdp_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              irq
);

    localparam int PER_W = DATA_W - 1;

    logic             cmd_cfg_we, bp_cfg_we, cmd_first, cmd_last;
    logic             cmd_en, bp_en, cmd_to, bp_to;
    logic [PER_W-1:0] cmd_per, bp_per;
    logic [1:0]       status;

    wd_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .cmd_to     (cmd_to),
        .bp_to      (bp_to),
        .cmd_en     (cmd_en),
        .cmd_per    (cmd_per),
        .bp_en      (bp_en),
        .bp_per     (bp_per),
        .rdata      (bus_rdata),
        .status_o   (status),
        .cmd_cfg_we (cmd_cfg_we),
        .bp_cfg_we  (bp_cfg_we),
        .cmd_first  (cmd_first),
        .cmd_last   (cmd_last)
    );

    wd_countdown #(
        .MODE  (WD_EVENT),
        .PER_W (PER_W)
    ) u_cmd_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cmd_cfg_we),
        .cfg_en     (bus_wdata[DATA_W-1]),
        .cfg_period (bus_wdata[PER_W-1:0]),
        .start_i    (cmd_first),
        .stop_i     (cmd_last),
        .en_o       (cmd_en),
        .period_o   (cmd_per),
        .timeout_o  (cmd_to)
    );

    wd_countdown #(
        .MODE  (WD_LEVEL),
        .PER_W (PER_W)
    ) u_bp_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (bp_cfg_we),
        .cfg_en     (bus_wdata[DATA_W-1]),
        .cfg_period (bus_wdata[PER_W-1:0]),
        .start_i    (cmd_valid),
        .stop_i     (cmd_ready),
        .en_o       (bp_en),
        .period_o   (bp_per),
        .timeout_o  (bp_to)
    );

    assign irq = |status;

    // R5: a disabled watchdog never reports a timeout
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_en || cmd_cfg_we) |-> !cmd_to);

    // R12: the interrupt line rises only after some timeout was reported
    p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_to || bp_to));

endmodule

// File: tb/tb_txn_watchdog_pair.sv
// Self-checking bench: directed corner cases plus seeded random handshake
// streams scored against a stalled-cycle run-length model.
module tb_txn_watchdog_pair;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int WD_CYCLES = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready = 1'b0;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    txn_watchdog_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] tmr_word(input logic en, input int unsigned per);
        return {en, per[30:0]};
    endfunction

    function automatic logic [31:0] st_word(input logic c, input logic b);
        logic [31:0] w;
        w = '0;
        w[4] = c;
        w[5] = b;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = ADDR_W'(a);
        bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_rd = 1'b1;
        bus_addr = ADDR_W'(a);
        #2;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic check_status(input string tag, input logic c, input logic b);
        logic [31:0] d;
        bus_read(4, d);
        check(tag, d, st_word(c, b));
        check({tag, " irq R12"}, {31'd0, irq}, {31'd0, c | b});
    endtask

    initial begin
        #(WD_CYCLES * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("[TB] FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset values
        bus_read(2, d); check("R1 cmd tmr reset", d, 32'h7FFF_FFFF);
        bus_read(3, d); check("R1 bp tmr reset", d, 32'h7FFF_FFFF);
        check_status("R1 status reset", 1'b0, 1'b0);

        // R2: readback of register fields
        bus_write(2, tmr_word(1'b0, 31'h1234567));
        bus_read(2, d); check("R2 cmd tmr readback", d, tmr_word(1'b0, 31'h1234567));
        bus_write(3, tmr_word(1'b0, 31'h5A5A5A5));
        bus_read(3, d); check("R2 bp tmr readback", d, tmr_word(1'b0, 31'h5A5A5A5));
        bus_read(0, d); check("R2 offset 0 reads zero", d, 32'h0);

        // R5: disabled command timer ignores command writes
        bus_write(2, tmr_word(1'b0, 2));
        bus_write(0, 32'hABCD);
        tick(10);
        check_status("R5 cmd disabled no timeout", 1'b0, 1'b0);

        // R3: timeout after N+1 edges, data rewrite does not restart (R4)
        bus_write(2, tmr_word(1'b1, 6));
        bus_write(0, 32'h1);
        tick(2);
        bus_write(0, 32'h2);
        tick(3);
        check_status("R3 cmd before expiry", 1'b0, 1'b0);
        tick(1);
        check_status("R3 cmd expired bit4", 1'b1, 1'b0);

        // R8: enable cleared, period kept, no second timeout
        bus_read(2, d); check("R8 cmd enable cleared", d, tmr_word(1'b0, 6));
        bus_write(4, st_word(1'b1, 1'b0));
        bus_write(0, 32'h3);
        tick(12);
        check_status("R8 cmd no retrigger", 1'b0, 1'b0);

        // R9: write 0 leaves bit; re-enable leaves bit; write 1 clears
        bus_write(2, tmr_word(1'b1, 0));
        bus_write(0, 32'h4);
        tick(1);
        check_status("R10 cmd period0 expiry", 1'b1, 1'b0);
        bus_write(4, 32'h0);
        check_status("R9 write0 no effect", 1'b1, 1'b0);
        bus_write(2, tmr_word(1'b1, 50));
        check_status("R9 sticky after re-enable", 1'b1, 1'b0);
        bus_write(4, st_word(1'b1, 1'b0));
        check_status("R9 write1 clears", 1'b0, 1'b0);

        // R4: completion stops the timer; re-arm with full period
        bus_write(2, tmr_word(1'b1, 5));
        bus_write(0, 32'h5);
        tick(3);
        bus_write(1, 32'h6);
        tick(10);
        check_status("R4 completed no timeout", 1'b0, 1'b0);
        bus_write(0, 32'h7);
        tick(5);
        check_status("R4 rearm before expiry", 1'b0, 1'b0);
        tick(1);
        check_status("R4 rearm expiry", 1'b1, 1'b0);
        bus_write(4, st_word(1'b1, 1'b0));

        // R4: completing write on the expiry edge wins
        bus_write(2, tmr_word(1'b1, 2));
        bus_write(0, 32'h8);
        tick(2);
        bus_write(1, 32'h9);
        tick(4);
        check_status("R4 last word beats expiry", 1'b0, 1'b0);
        bus_read(2, d); check("R4 still enabled", d, tmr_word(1'b1, 2));

        // R11: rewrite while counting reloads the new period
        bus_write(2, tmr_word(1'b1, 20));
        bus_write(0, 32'hA);
        tick(2);
        bus_write(2, tmr_word(1'b1, 3));
        tick(3);
        check_status("R11 before new expiry", 1'b0, 1'b0);
        tick(1);
        check_status("R11 new period expiry", 1'b1, 1'b0);
        bus_write(4, st_word(1'b1, 1'b0));

        // R9: clear and new timeout on the same edge, set wins
        bus_write(2, tmr_word(1'b1, 0));
        bus_write(0, 32'hB);
        bus_write(4, st_word(1'b1, 1'b0));
        check_status("R9 set beats clear", 1'b1, 1'b0);
        bus_write(4, st_word(1'b1, 1'b0));

        // R5: disabled backpressure timer ignores long stall
        bus_write(3, tmr_word(1'b0, 1));
        cmd_valid = 1'b1; cmd_ready = 1'b0;
        tick(10);
        cmd_valid = 1'b0;
        check_status("R5 bp disabled no timeout", 1'b0, 1'b0);

        // R6: N stalled cycles ok, N+1 trips bit5
        bus_write(3, tmr_word(1'b1, 4));
        cmd_valid = 1'b1; cmd_ready = 1'b0;
        tick(4);
        check_status("R6 bp N stalls", 1'b0, 1'b0);
        tick(1);
        check_status("R6 bp N+1 stalls", 1'b0, 1'b1);
        cmd_valid = 1'b0;
        bus_read(3, d); check("R8 bp enable cleared", d, tmr_word(1'b0, 4));
        bus_write(4, st_word(1'b0, 1'b1));

        // R7: handshake and idle cycles reload the count
        bus_write(3, tmr_word(1'b1, 4));
        cmd_valid = 1'b1; cmd_ready = 1'b0; tick(4);
        cmd_ready = 1'b1; tick(1);
        cmd_ready = 1'b0; tick(4);
        cmd_valid = 1'b0; tick(1);
        cmd_valid = 1'b1; tick(4);
        check_status("R7 reloads prevent timeout", 1'b0, 1'b0);
        tick(1);
        check_status("R7 final stall trips", 1'b0, 1'b1);
        cmd_valid = 1'b0;
        bus_write(4, st_word(1'b0, 1'b1));

        // R10: bp period 0 trips on first stalled cycle
        bus_write(3, tmr_word(1'b1, 0));
        cmd_valid = 1'b1; cmd_ready = 1'b0; tick(1);
        cmd_valid = 1'b0;
        check_status("R10 bp period0", 1'b0, 1'b1);
        bus_write(4, st_word(1'b0, 1'b1));

        // R6/R7: random handshake streams against run-length model
        for (int t = 0; t < 20; t++) begin
            int unsigned per;
            int stall;
            bit fired;
            per = $urandom_range(0, 5);
            cmd_valid = 1'b0; cmd_ready = 1'b0;
            bus_write(3, tmr_word(1'b1, per));
            stall = 0;
            fired = 1'b0;
            for (int c = 0; c < 40; c++) begin
                logic v, r;
                v = ($urandom % 4) != 0;
                r = ($urandom % 2) != 0;
                cmd_valid = v; cmd_ready = r;
                tick(1);
                if (!fired) begin
                    if (v && !r) stall++;
                    else stall = 0;
                    if (stall == int'(per) + 1) fired = 1'b1;
                end
                bus_read(4, d);
                check($sformatf("R6 R7 random trial %0d cycle %0d", t, c), d, st_word(1'b0, fired));
            end
            cmd_valid = 1'b0;
            bus_write(4, st_word(1'b0, 1'b1));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule